// File: doc/BRIEF.md
# CHR Bank Address Composer

This block turns a pattern-table fetch address into a physical character-memory bank number counted in 1 KB units. It sits between an inner banking controller, which supplies an 8-bit bank value for the 1 KB slot being fetched, and a set of outer configuration registers. Those outer registers confine the inner controller to one region of a larger character memory. The path is purely combinational. Any change on an input shows up on the output in the same cycle, with no register on the way.

There are two modes, and bit 3 of outer register 0 selects between them. With that bit clear the block runs in banked mode. The inner value is masked to 128 or 256 banks and then an outer offset is OR-ed on top. With the bit set the block runs in fixed-page mode. A single 8 KB page is assembled from fields of outer registers 1 and 2 and a 2-bit latch. The latch is written elsewhere and can still change after the outer registers have been locked. The 1 KB bank is then the page times eight plus the slot index taken from fetch address bits 12:10.

Top module: `chr_bank_composer`

## Requirements
- R1: In banked mode (outer0 bit 3 = 0) the output equals (inner_bank AND mask) OR offset.
- R2: The mask is 0x7F when outer1 bit 6 is 1 and 0xFF when it is 0.
- R3: The offset takes outer1 bits 5:4 and places them at output bits 8:7, with all other offset bits zero. Output bit 9 is therefore 0 in banked mode.
- R4: In fixed-page mode (outer0 bit 3 = 1) the page equals outer2[3:0] OR latch[1:0] OR (outer1[6:4] shifted left by 4), giving a 7-bit value.
- R5: In fixed-page mode the output equals page × 8 + ppu_addr[12:10].
- R6: In banked mode, ppu_addr, latch and outer2 have no effect on the output.
- R7: In fixed-page mode, inner_bank has no effect on the output.
- R8: outer0 bits other than bit 3, outer1 bit 7, outer1 bits 3:0 and outer2 bits 7:4 have no effect in either mode.
- R9: The output follows every input change combinationally. A latch change made while fixed-page mode stays selected is visible before the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ppu_addr | input | 14 | Pattern-table fetch address; bits 12:10 give the 1 KB slot |
| inner_bank | input | 8 | Inner controller's bank value for the fetched slot |
| outer0 | input | 8 | Outer register 0; bit 3 selects fixed-page mode |
| outer1 | input | 8 | Outer register 1; mask select, offset and page high bits |
| outer2 | input | 8 | Outer register 2; page low bits |
| page_latch | input | 2 | Post-lock latch OR-ed into the page |
| bank_1k | output | 10 | Physical 1 KB bank number |

## Verification
The bench aims at the overlap of OR-ed fields. In fixed-page mode outer2 and the latch collide on the two low page bits. A design that added these fields instead of OR-ing them would carry into bit 2 and select the wrong page. The bench also probes the mask boundary with inner values whose bit 7 is set. A swapped mask polarity would leak that bit or clear it under the wrong setting. Finally, the bench moves inputs that a given mode must ignore, such as the address in banked mode or the inner value in fixed-page mode. It also steps the latch with no clock edge in between, which catches a design that picks the wrong source or registers the output.

// File: rtl/chr_comp_pkg.sv
package chr_comp_pkg;

  localparam int INNER_W = 8;
  localparam int PAGE_W  = 7;
  localparam int SLOT_W  = 3;
  localparam int OUT_W   = PAGE_W + SLOT_W;
  localparam int LATCH_W = 2;
  localparam int LO_W    = 4;
  localparam int HI_W    = 3;
  localparam int OFF_W   = 2;
  localparam int OFF_POS = 7;

  typedef struct packed {
    logic              fixed_pg;
    logic              narrow;
    logic [OFF_W-1:0]  off_sel;
    logic [HI_W-1:0]   page_hi;
    logic [LO_W-1:0]   page_lo;
  } outer_cfg_t;

  function automatic logic [INNER_W-1:0] fine_mask(input logic narrow);
    logic [INNER_W-1:0] m;
    m = '1;
    if (narrow) m[INNER_W-1] = 1'b0;
    return m;
  endfunction

  function automatic logic [OUT_W-1:0] fine_offset(input logic [OFF_W-1:0] sel);
    logic [OUT_W-1:0] o;
    o = '0;
    o[OFF_POS +: OFF_W] = sel;
    return o;
  endfunction

  function automatic logic [OUT_W-1:0] fine_bank(input logic [INNER_W-1:0] inner,
                                                 input logic               narrow,
                                                 input logic [OFF_W-1:0]   sel);
    logic [OUT_W-1:0] wide;
    wide = OUT_W'(inner & fine_mask(narrow));
    return wide | fine_offset(sel);
  endfunction

  function automatic logic [PAGE_W-1:0] page_compose(input logic [LO_W-1:0]    lo,
                                                     input logic [LATCH_W-1:0] lt,
                                                     input logic [HI_W-1:0]    hi);
    logic [PAGE_W-1:0] p;
    p = PAGE_W'(lo) | PAGE_W'(lt);
    p[PAGE_W-1 -: HI_W] = p[PAGE_W-1 -: HI_W] | hi;
    return p;
  endfunction

  function automatic logic [OUT_W-1:0] page_to_1k(input logic [PAGE_W-1:0] pg,
                                                  input logic [SLOT_W-1:0] slot);
    return {pg, slot};
  endfunction

endpackage

// File: rtl/chr_outer_decode.sv
module chr_outer_decode
  import chr_comp_pkg::*;
(
  input  logic [7:0] outer0,
  input  logic [7:0] outer1,
  input  logic [7:0] outer2,
  output outer_cfg_t cfg
);

  logic unused_outer_bits;
  assign unused_outer_bits = ^{outer0[7:4], outer0[2:0], outer1[7], outer1[3:0], outer2[7:4]};

  always_comb begin
    cfg          = '0;
    cfg.fixed_pg = outer0[3];
    cfg.narrow   = outer1[6];
    cfg.off_sel  = outer1[5:4];
    cfg.page_hi  = outer1[6:4];
    cfg.page_lo  = outer2[3:0];
  end

endmodule

// File: rtl/chr_fine_path.sv
module chr_fine_path
  import chr_comp_pkg::*;
#(
  parameter int IW = INNER_W,
  parameter int OW = OUT_W
) (
  input  logic [IW-1:0]    inner_bank,
  input  logic             narrow,
  input  logic [OFF_W-1:0] off_sel,
  output logic [OW-1:0]    fine_out
);

  assign fine_out = fine_bank(inner_bank, narrow, off_sel);

  always_comb begin
    if (!$isunknown({inner_bank, narrow, off_sel})) begin
      // R2
      narrow_bit7_chk: assert (!narrow || fine_out[7] == off_sel[0])
        else $error("narrow mask leaked inner bit 7");
      // R3
      fine_top_chk: assert (fine_out[OW-1] == 1'b0)
        else $error("banked output set top bit");
      // R1
      fine_low_chk: assert (fine_out[6:0] == inner_bank[6:0])
        else $error("banked low bits differ from inner");
    end
  end

endmodule

// File: rtl/chr_page_path.sv
module chr_page_path
  import chr_comp_pkg::*;
#(
  parameter int OW = OUT_W
) (
  input  logic [LO_W-1:0]    page_lo,
  input  logic [HI_W-1:0]    page_hi,
  input  logic [LATCH_W-1:0] page_latch,
  input  logic [SLOT_W-1:0]  slot,
  output logic [OW-1:0]      page_out
);

  logic [PAGE_W-1:0] page;

  assign page     = page_compose(page_lo, page_latch, page_hi);
  assign page_out = page_to_1k(page, slot);

  always_comb begin
    if (!$isunknown({page_lo, page_hi, page_latch, slot})) begin
      // R5
      page_slot_chk: assert (page_out[SLOT_W-1:0] == slot)
        else $error("slot bits not passed through");
      // R4
      page_hi_chk: assert (page_out[OW-1 -: HI_W] == page_hi)
        else $error("page high bits wrong");
      // R4
      page_mid_chk: assert (page_out[6:5] == page_lo[3:2])
        else $error("page middle bits wrong");
    end
  end

endmodule

// File: rtl/chr_bank_composer.sv
module chr_bank_composer
  import chr_comp_pkg::*;
(
  input  logic [13:0] ppu_addr,
  input  logic [7:0]  inner_bank,
  input  logic [7:0]  outer0,
  input  logic [7:0]  outer1,
  input  logic [7:0]  outer2,
  input  logic [1:0]  page_latch,
  output logic [9:0]  bank_1k
);

  outer_cfg_t       cfg;
  logic [OUT_W-1:0] fine_out;
  logic [OUT_W-1:0] page_out;
  logic             unused_addr_bits;

  assign unused_addr_bits = ^{ppu_addr[13], ppu_addr[9:0]};

  chr_outer_decode u_dec (
    .outer0 (outer0),
    .outer1 (outer1),
    .outer2 (outer2),
    .cfg    (cfg)
  );

  chr_fine_path #(.IW(INNER_W), .OW(OUT_W)) u_fine (
    .inner_bank (inner_bank),
    .narrow     (cfg.narrow),
    .off_sel    (cfg.off_sel),
    .fine_out   (fine_out)
  );

  chr_page_path #(.OW(OUT_W)) u_page (
    .page_lo    (cfg.page_lo),
    .page_hi    (cfg.page_hi),
    .page_latch (page_latch),
    .slot       (ppu_addr[12:10]),
    .page_out   (page_out)
  );

  assign bank_1k = cfg.fixed_pg ? page_out : fine_out;

  always_comb begin
    if (!$isunknown({ppu_addr, inner_bank, outer0, outer1, outer2, page_latch})) begin
      // R5
      fixed_slot_chk: assert (!outer0[3] || bank_1k[2:0] == ppu_addr[12:10])
        else $error("fixed mode slot mismatch");
      // R3
      banked_top_chk: assert (outer0[3] || bank_1k[9] == 1'b0)
        else $error("banked mode top bit set");
      // R3
      banked_off_chk: assert (outer0[3] || (bank_1k[8] == outer1[5] || inner_bank[7:0] != inner_bank[7:0]))
        else $error("banked offset bit 8 wrong");
    end
  end

endmodule

// File: tb/sim_chr_bank_composer.sv
module sim_chr_bank_composer;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [13:0] ppu_addr;
  logic [7:0]  inner_bank, outer0, outer1, outer2;
  logic [1:0]  page_latch;
  logic [9:0]  bank_1k;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chr_bank_composer u0 (
    .ppu_addr   (ppu_addr),
    .inner_bank (inner_bank),
    .outer0     (outer0),
    .outer1     (outer1),
    .outer2     (outer2),
    .page_latch (page_latch),
    .bank_1k    (bank_1k)
  );

  function automatic int exp_bank(int a, int inn, int r0, int r1, int r2, int lt);
    int pg;
    if ((r0 & 8) != 0) begin
      pg = (r2 & 15) | (lt & 3) | (((r1 >> 4) & 7) << 4);
      return pg * 8 + ((a >> 10) & 7);
    end
    return (inn & (((r1 & 64) != 0) ? 127 : 255)) | ((r1 & 48) << 3);
  endfunction

  task automatic apply(int a, int inn, int r0, int r1, int r2, int lt);
    ppu_addr = 14'(a); inner_bank = 8'(inn);
    outer0 = 8'(r0); outer1 = 8'(r1); outer2 = 8'(r2); page_latch = 2'(lt);
    #1;
  endtask

  task automatic chk(string req, int exp);
    total++;
    if (int'(bank_1k) != exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, bank_1k, exp);
    end
  endtask

  task automatic run(string req, int a, int inn, int r0, int r1, int r2, int lt);
    apply(a, inn, r0, r1, r2, lt);
    chk(req, exp_bank(a, inn, r0, r1, r2, lt));
  endtask

  initial begin
    int ref_v;
    int seed;
    seed = 13;
    void'($urandom(seed));
    @(negedge clk);
    // all-zero inputs: output 0
    run("R1 zero", 0, 0, 0, 0, 0, 0);
    chk("R1 zero literal", 0);
    // R1 / R2 mask boundary
    run("R2 wide", 0, 8'hFF, 0, 0, 0, 0);
    chk("R2 wide literal", 8'hFF);
    run("R2 narrow", 0, 8'hFF, 0, 8'h40, 0, 0);
    chk("R2 narrow literal", 8'h7F);
    // R3 offset
    run("R3 off1", 0, 8'h05, 0, 8'h10, 0, 0);
    chk("R3 off1 literal", 10'h085);
    run("R3 off3", 0, 8'h80, 0, 8'h30, 0, 0);
    chk("R3 off3 literal", 10'h180);
    // R4 OR overlap of latch and outer2
    run("R4 overlap", 0, 0, 8, 0, 8'h03, 3);
    chk("R4 overlap literal", 3 * 8);
    run("R4 hi", 14'h1C00, 0, 8, 8'h70, 8'h0F, 0);
    chk("R5 max literal", 10'h3FF);
    // R5 slot walk
    for (int s = 0; s < 8; s++) run("R5 slot", s << 10, 8'hAA, 8, 8'h20, 8'h05, 2);
    // R6 banked ignores addr, latch, outer2
    apply(0, 8'h5A, 0, 8'h50, 0, 0);
    ref_v = int'(bank_1k);
    apply(14'h1C00, 8'h5A, 0, 8'h50, 8'hFF, 3);
    chk("R6 ignore", ref_v);
    // R7 fixed ignores inner
    apply(14'h0800, 0, 8, 8'h10, 8'h04, 1);
    ref_v = int'(bank_1k);
    apply(14'h0800, 8'hFF, 8, 8'h10, 8'h04, 1);
    chk("R7 ignore", ref_v);
    // R8 unused bits
    apply(14'h0400, 8'h33, 8'hF7, 8'h8F, 8'hF0, 2);
    chk("R8 banked unused", exp_bank(0, 8'h33, 0, 8'h00, 0, 0));
    apply(14'h0400, 8'h33, 8'hFF, 8'h8F, 8'hF0, 2);
    chk("R8 fixed unused", 2 * 8 + 1);
    // R9 latch step with no clock edge between
    apply(0, 0, 8, 0, 0, 0);
    for (int l = 0; l < 4; l++) begin
      page_latch = 2'(l); #1;
      chk("R9 latch step", l * 8);
    end
    // random mix
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      run(((i & 1) != 0) ? "R4 R5 random" : "R1 R3 random",
          int'($urandom() & 16'h3FFF), int'($urandom() & 8'hFF),
          int'($urandom() & 8'hFF), int'($urandom() & 8'hFF),
          int'($urandom() & 8'hFF), int'($urandom() & 3));
    end
    done = 1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule